// File: doc/BRIEF.md
# Page-Buffered Nonvolatile Write Controller

This block is the host-side write path of a memory that is programmed one page at a time. The host bus works like an asynchronous SRAM bus: active-low chip enable, write enable and output enable, a 17-bit address and an 8-bit data bus. The block samples this bus with its own system clock. Each host byte write goes into a 128-byte page buffer. A per-byte mask records which positions have been written.

An inactivity timer ends the load. After a set number of clocks with no new write strobe, the block sends one program request to the array side. The request carries the page number and a 1024-bit page image. Every position the host did not write appears as FFh in that image. The request and the busy flag stay high until the array returns an acknowledge.

The first accepted byte of a load fixes the page. A later byte with a different page number is dropped and sets a sticky error flag. Writes that arrive while the block is busy are ignored.

Top module: `pgwr_ctrl`

## Requirements
- R1: A write strobe exists only while chip enable is low, write enable is low and output enable is high. Any other combination (for example output enable low) loads nothing and starts no program.
- R2: The address is taken on the clock where the strobe first becomes active, which is the later of the two enable falling edges. Address changes later in the same strobe have no effect.
- R3: The data byte is taken on the clock where the strobe first ends, which is the earlier of the two enable rising edges. Earlier data values in the same strobe have no effect.
- R4: Address bits [6:0] select the byte position in the page and bits [16:7] select the page, which is output as `prog_page`. Bytes may arrive in any order.
- R5: Every accepted byte restarts the inactivity timer. The timer pauses while a strobe is active. A gap of up to `BLC_CYC` clocks between bytes (with `BLC_CYC` < `TMO_CYC`) keeps the block in the same load.
- R6: If no strobe starts, `prog_req` and `busy` rise on the `TMO_CYC`-th clock edge after the edge that took the last accepted byte.
- R7: In `prog_image`, byte position i occupies bits [8i+7:8i]. Each position that was not written in the current load reads FFh.
- R8: The written-byte mask is cleared when a new load begins, so bytes from an earlier page never appear in a later image.
- R9: During a load, a byte whose page differs from the load's page is not stored. It sets `page_err`, which stays high until reset.
- R10: `busy` and `prog_req` stay high, with page and image unchanged, until `prog_ack` is seen. They drop on the next edge. A strobe that starts while busy is ignored, even if it ends after the acknowledge.
- R11: After reset, `busy`, `prog_req` and `page_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_ce_n | input | 1 | Host chip enable, active low |
| bus_we_n | input | 1 | Host write enable, active low |
| bus_oe_n | input | 1 | Host output enable, active low |
| bus_addr | input | 17 | Host byte address |
| bus_data | input | 8 | Host write data |
| prog_ack | input | 1 | Array finished programming the page |
| prog_req | output | 1 | Page program request to the array |
| busy | output | 1 | Programming in progress |
| page_err | output | 1 | Sticky flag: a byte for another page was dropped |
| prog_page | output | 10 | Page number being programmed |
| prog_image | output | 1024 | Full page image, unwritten bytes FFh |

## Verification
The bench uses several stimulus patterns, and each one separates correct from wrong behaviour on a specific point:
- **Single byte with changing bus values.** The address and data change partway through one strobe. This separates capture at the start of the strobe from capture at its end, and shows that all other positions fill with FFh.
- **Three bytes out of order.** The bytes are spaced `BLC_CYC` clocks apart. They must produce exactly one program, and its start is measured against the timeout.
- **Second page after a cross-page byte.** This shows the mask is cleared between loads and that the foreign byte is dropped while the error flag latches.
- **Ignored strobes.** Strobes with output enable low, and strobes that start while busy, must never start a load. This is confirmed by watching the request stay low over a full timeout.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_PROG = 2'd2
    } ld_state_e;

endpackage

// File: rtl/pgwr_strobe.sv
// Samples the host bus and turns the write strobe into start/end pulses.
module pgwr_strobe #(
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    output logic              wr_active,
    output logic              wr_start,
    output logic              wr_end,
    output logic [ADDR_W-1:0] cap_addr
);

    typedef struct packed {
        logic              act;
        logic [ADDR_W-1:0] addr;
    } stb_t;

    stb_t stb_d, stb_q;
    logic act_now;

    always_comb begin
        act_now  = !ce_n && !we_n && oe_n;
        wr_start = act_now && !stb_q.act;
        wr_end   = !act_now && stb_q.act;
        stb_d     = stb_q;
        stb_d.act = act_now;
        if (wr_start) begin
            stb_d.addr = addr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stb_q <= '0;
        end else begin
            stb_q <= stb_d;
        end
    end

    assign wr_active = act_now;
    assign cap_addr  = stb_q.addr;

endmodule

// File: rtl/pgwr_pagebuf.sv
// Page buffer with per-byte written mask; unwritten bytes read as all ones.
module pgwr_pagebuf #(
    parameter int OFS_W  = 7,
    parameter int DATA_W = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          clear,
    input  logic                          wr_en,
    input  logic [OFS_W-1:0]              wr_ofs,
    input  logic [DATA_W-1:0]             wr_data,
    output logic [(1<<OFS_W)*DATA_W-1:0]  image
);

    localparam int BYTES = 1 << OFS_W;

    typedef struct packed {
        logic [BYTES-1:0]             mask;
        logic [BYTES-1:0][DATA_W-1:0] data;
    } buf_t;

    buf_t buf_d, buf_q;

    always_comb begin
        buf_d = buf_q;
        if (clear) begin
            buf_d.mask = '0;
        end
        if (wr_en) begin
            buf_d.mask[wr_ofs] = 1'b1;
            buf_d.data[wr_ofs] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_q <= '0;
        end else begin
            buf_q <= buf_d;
        end
    end

    for (genvar i = 0; i < BYTES; i++) begin : g_img
        assign image[i*DATA_W +: DATA_W] = buf_q.mask[i] ? buf_q.data[i] : {DATA_W{1'b1}};
    end

endmodule

// File: rtl/pgwr_ctrl.sv
// Load sequencing: page lock, inactivity timer, program handshake.
module pgwr_ctrl
    import pgwr_pkg::*;
#(
    parameter int ADDR_W  = 17,
    parameter int DATA_W  = 8,
    parameter int OFS_W   = 7,
    parameter int BLC_CYC = 50000,
    parameter int TMO_CYC = 75000
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                bus_ce_n,
    input  logic                                bus_we_n,
    input  logic                                bus_oe_n,
    input  logic [ADDR_W-1:0]                   bus_addr,
    input  logic [DATA_W-1:0]                   bus_data,
    input  logic                                prog_ack,
    output logic                                prog_req,
    output logic                                busy,
    output logic                                page_err,
    output logic [ADDR_W-OFS_W-1:0]             prog_page,
    output logic [(1<<OFS_W)*DATA_W-1:0]        prog_image
);

    localparam int PAGE_W = ADDR_W - OFS_W;
    localparam int TMR_MX = (TMO_CYC > BLC_CYC) ? TMO_CYC : BLC_CYC;
    localparam int TMR_W  = $clog2(TMR_MX + 1);

    typedef struct packed {
        ld_state_e         st;
        logic [PAGE_W-1:0] page;
        logic [TMR_W-1:0]  tmr;
        logic              ok;
        logic              err;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              wr_active, wr_start, wr_end;
    logic [ADDR_W-1:0] cap_addr;
    logic              buf_clear, buf_wr, commit, page_hit;

    pgwr_strobe #(.ADDR_W(ADDR_W)) u_strobe (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce_n      (bus_ce_n),
        .we_n      (bus_we_n),
        .oe_n      (bus_oe_n),
        .addr      (bus_addr),
        .wr_active (wr_active),
        .wr_start  (wr_start),
        .wr_end    (wr_end),
        .cap_addr  (cap_addr)
    );

    pgwr_pagebuf #(.OFS_W(OFS_W), .DATA_W(DATA_W)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (buf_clear),
        .wr_en   (buf_wr),
        .wr_ofs  (cap_addr[OFS_W-1:0]),
        .wr_data (bus_data),
        .image   (prog_image)
    );

    always_comb begin
        ctl_d     = ctl_q;
        commit    = wr_end && ctl_q.ok;
        page_hit  = (cap_addr[ADDR_W-1:OFS_W] == ctl_q.page);
        buf_clear = 1'b0;
        buf_wr    = 1'b0;
        if (wr_start) begin
            ctl_d.ok = (ctl_q.st != ST_PROG);
        end
        case (ctl_q.st)
            ST_IDLE: begin
                if (commit) begin
                    buf_clear  = 1'b1;
                    buf_wr     = 1'b1;
                    ctl_d.page = cap_addr[ADDR_W-1:OFS_W];
                    ctl_d.tmr  = '0;
                    ctl_d.st   = ST_LOAD;
                end
            end
            ST_LOAD: begin
                if (commit && page_hit) begin
                    buf_wr    = 1'b1;
                    ctl_d.tmr = '0;
                end else begin
                    if (commit) begin
                        ctl_d.err = 1'b1;
                    end
                    if (!wr_active) begin
                        if (ctl_q.tmr == TMR_W'(TMO_CYC - 1)) begin
                            ctl_d.st = ST_PROG;
                        end else begin
                            ctl_d.tmr = ctl_q.tmr + 1'b1;
                        end
                    end
                end
            end
            ST_PROG: begin
                if (prog_ack) begin
                    ctl_d.st = ST_IDLE;
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q    <= '0;
            ctl_q.st <= ST_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign prog_req  = (ctl_q.st == ST_PROG);
    assign busy      = (ctl_q.st == ST_PROG);
    assign page_err  = ctl_q.err;
    assign prog_page = ctl_q.page;

endmodule

// File: rtl/pgwr_chk.sv
module pgwr_chk #(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8,
    parameter int OFS_W  = 7
) (
    input logic                               clk,
    input logic                               rst_n,
    input logic                               bus_ce_n,
    input logic                               bus_we_n,
    input logic                               bus_oe_n,
    input logic                               prog_ack,
    input logic                               busy,
    input logic                               page_err,
    input logic [ADDR_W-OFS_W-1:0]            prog_page,
    input logic [(1<<OFS_W)*DATA_W-1:0]       prog_image
);

    AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        busy && prog_ack |=> !busy);                                   // R10

    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !prog_ack |=> busy && $stable(prog_page) && $stable(prog_image)); // R10

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        page_err |=> page_err);                                        // R9

    AST_NO_PROG_IN_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(bus_ce_n || bus_we_n || !bus_oe_n));     // R5

endmodule

bind pgwr_ctrl pgwr_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFS_W(OFS_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_ce_n   (bus_ce_n),
    .bus_we_n   (bus_we_n),
    .bus_oe_n   (bus_oe_n),
    .prog_ack   (prog_ack),
    .busy       (busy),
    .page_err   (page_err),
    .prog_page  (prog_page),
    .prog_image (prog_image)
);

// File: tb/tb_pgwr_ctrl.sv
`timescale 1ns/1ps
module tb_pgwr_ctrl;

    localparam int BLC = 8;
    localparam int TMO = 12;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [16:0]  addr = '0;
    logic [7:0]   data = '0;
    logic         ack = 1'b0;
    logic         prog_req, busy, page_err;
    logic [9:0]   prog_page;
    logic [1023:0] prog_image;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    always #2 clk = ~clk;

    pgwr_ctrl #(.BLC_CYC(BLC), .TMO_CYC(TMO)) dut (
        .clk(clk), .rst_n(rst_n), .bus_ce_n(ce_n), .bus_we_n(we_n), .bus_oe_n(oe_n),
        .bus_addr(addr), .bus_data(data), .prog_ack(ack), .prog_req(prog_req),
        .busy(busy), .page_err(page_err), .prog_page(prog_page), .prog_image(prog_image)
    );

    // reference model: 0 idle, 1 loading, 2 programming
    int          m_st, m_tmr;
    bit          m_act, m_ok, m_err;
    logic [16:0] m_addr;
    logic [9:0]  m_page;
    logic [7:0]  m_data [128];
    bit          m_mask [128];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 0; m_tmr = 0; m_act = 0; m_ok = 0; m_err = 0; m_addr = '0; m_page = '0;
            for (int i = 0; i < 128; i++) begin m_mask[i] = 0; m_data[i] = '0; end
        end else begin
            bit act, start, fin, step;
            int st0;
            act = !ce_n && !we_n && oe_n;
            start = act && !m_act;
            fin = !act && m_act;
            st0 = m_st;
            step = 0;
            if (st0 == 2) begin
                if (ack) m_st = 0;
            end else if (fin && m_ok) begin
                if (st0 == 0) begin
                    for (int i = 0; i < 128; i++) m_mask[i] = 0;
                    m_page = m_addr[16:7];
                    m_mask[m_addr[6:0]] = 1; m_data[m_addr[6:0]] = data;
                    m_st = 1; m_tmr = 0;
                end else if (m_addr[16:7] == m_page) begin
                    m_mask[m_addr[6:0]] = 1; m_data[m_addr[6:0]] = data;
                    m_tmr = 0;
                end else begin
                    m_err = 1; step = 1;
                end
            end else if (st0 == 1) begin
                step = 1;
            end
            if (step && !act) begin
                if (m_tmr == TMO - 1) m_st = 2;
                else m_tmr++;
            end
            if (start) begin m_addr = addr; m_ok = (st0 != 2); end
            m_act = act;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R10 busy vs model", {31'd0, busy}, {31'd0, m_st == 2});
            chk("R6 prog_req vs model", {31'd0, prog_req}, {31'd0, m_st == 2});
            chk("R9 page_err vs model", {31'd0, page_err}, {31'd0, m_err});
            if (m_st == 2) begin
                chk("R4 prog_page vs model", {22'd0, prog_page}, {22'd0, m_page});
                for (int i = 0; i < 128; i++) begin
                    chk("R7 image byte vs model", {24'd0, prog_image[i*8 +: 8]},
                        {24'd0, m_mask[i] ? m_data[i] : 8'hFF});
                end
            end
        end
    end

    function automatic logic [31:0] img(input int ofs);
        return {24'd0, prog_image[ofs*8 +: 8]};
    endfunction

    task automatic wr(input logic [16:0] a1, input logic [16:0] a2,
                      input logic [7:0] d1, input logic [7:0] d2, input logic oe);
        @(negedge clk); ce_n = 0; we_n = 0; oe_n = oe; addr = a1; data = d1;
        @(negedge clk); addr = a2; data = d2;
        @(negedge clk); we_n = 1;
        @(negedge clk); ce_n = 1; addr = '0; data = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_req(output int cnt);
        cnt = 0;
        while (!prog_req && cnt < 200) begin @(negedge clk); cnt++; end
    endtask

    task automatic do_ack();
        @(negedge clk); ack = 1;
        @(negedge clk); ack = 0;
    endtask

    initial begin
        int cnt;
        bit seen;
        repeat (3) @(negedge clk);
        chk("R11 busy after reset", {31'd0, busy}, 32'd0);
        chk("R11 req after reset", {31'd0, prog_req}, 32'd0);
        chk("R11 err after reset", {31'd0, page_err}, 32'd0);
        rst_n = 1;
        idle(2);

        // single byte, address and data moving inside the strobe
        wr({10'd3, 7'd5}, {10'd9, 7'd77}, 8'h11, 8'hA5, 1'b1);
        wait_req(cnt);
        chk("R6 clocks from last byte to request", cnt, TMO);
        chk("R4 page number", {22'd0, prog_page}, 32'd3);
        chk("R3 data taken at strobe end", img(5), 32'hA5);
        chk("R2 later address ignored", img(77), 32'hFF);
        chk("R7 unwritten byte is FF", img(0), 32'hFF);
        wr({10'd3, 7'd6}, {10'd3, 7'd6}, 8'h12, 8'h12, 1'b1);
        chk("R10 still busy before ack", {31'd0, busy}, 32'd1);
        chk("R10 write while busy ignored", img(6), 32'hFF);
        do_ack();
        chk("R10 busy released after ack", {31'd0, busy}, 32'd0);
        seen = 0;
        for (int i = 0; i < TMO + 4; i++) begin @(negedge clk); if (prog_req) seen = 1; end
        chk("R10 busy-time write started no load", {31'd0, seen}, 32'd0);

        // three bytes out of order, spaced by the byte-load window
        wr({10'h155, 7'd127}, {10'h155, 7'd127}, 8'hC1, 8'hC1, 1'b1);
        seen = 0;
        for (int i = 0; i < BLC; i++) begin @(negedge clk); if (prog_req) seen = 1; end
        wr({10'h155, 7'd0}, {10'h155, 7'd0}, 8'hC2, 8'hC2, 1'b1);
        for (int i = 0; i < BLC; i++) begin @(negedge clk); if (prog_req) seen = 1; end
        wr({10'h155, 7'd64}, {10'h155, 7'd64}, 8'hC3, 8'hC3, 1'b1);
        chk("R5 no program between spaced bytes", {31'd0, seen}, 32'd0);
        wait_req(cnt);
        chk("R5 timer restarted by last byte", cnt, TMO);
        chk("R4 page upper bits", {22'd0, prog_page}, 32'h155);
        chk("R4 byte 127", img(127), 32'hC1);
        chk("R4 byte 0", img(0), 32'hC2);
        chk("R4 byte 64", img(64), 32'hC3);
        do_ack();

        // new page, then a byte for a foreign page
        wr({10'd7, 7'd3}, {10'd7, 7'd3}, 8'h33, 8'h33, 1'b1);
        idle(2);
        wr({10'd8, 7'd4}, {10'd8, 7'd4}, 8'h44, 8'h44, 1'b1);
        chk("R9 error raised by foreign page", {31'd0, page_err}, 32'd1);
        wait_req(cnt);
        chk("R9 page kept from first byte", {22'd0, prog_page}, 32'd7);
        chk("R9 foreign byte not stored", img(4), 32'hFF);
        chk("R8 earlier load byte 127 cleared", img(127), 32'hFF);
        chk("R8 earlier load byte 0 cleared", img(0), 32'hFF);
        chk("R8 new byte present", img(3), 32'h33);
        do_ack();

        // output enable low: not a write
        wr({10'd2, 7'd1}, {10'd2, 7'd1}, 8'h55, 8'h55, 1'b0);
        seen = 0;
        for (int i = 0; i < TMO + 4; i++) begin @(negedge clk); if (prog_req) seen = 1; end
        chk("R1 strobe with output enable low ignored", {31'd0, seen}, 32'd0);
        chk("R9 error still set", {31'd0, page_err}, 32'd1);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_err++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule